// File: doc/BRIEF.md
# Binary Sub-Second Alarm Matcher

This block watches a free-running binary counter and raises a sticky flag for each of two alarms when the counter's low-order bits equal a stored alarm value. Each alarm has a programmable compare width. Only counter bits below that width take part in the compare, so software can choose whether an alarm fires once per full wrap of the counter or once every 2^width counts. The block evaluates the compare only in cycles where the counter reports an update.

Software reaches the block through a single-cycle register port. Each alarm value has its own full-width register. A second, aliased register per alarm exposes the low 15 bits of the same storage together with that alarm's compare width. Both alarm values and their widths are write-protected while the alarm is enabled, unless the initialization-mode input is high.

The block has two resets. The backup reset clears the stored alarm configuration. The system reset clears only the enables and flags, so the configuration survives it.

Top module: `subsec_alarm_match`

## Requirements
- R1: The full-width alarm value for alarm A is at offset 0x70 and for alarm B at 0x74. When unlocked, a write stores all 32 bits and a read returns them.
- R2: The aliased register for alarm A is at 0x44 and for alarm B at 0x48. In it, bits 14:0 are the same storage as bits 14:0 of that alarm's value, and bits 29:24 hold the compare width. A write there leaves value bits 31:15 unchanged. All other bits read 0.
- R3: A write to an alarm's value or aliased register is ignored while that alarm's enable is 1 and `init_mode` is 0. Such writes take effect when the enable is 0 or `init_mode` is 1.
- R4: The control register at 0x18 holds the alarm A enable in bit 0 and the alarm B enable in bit 1. It is always writable and reads back.
- R5: A match needs counter bits 0 to width-1 to equal the same alarm value bits, and higher bits are ignored. Width 0 matches on every update, and widths above 32 behave as 32.
- R6: A flag sets on the clock edge after a cycle with `cnt_tick` high, the alarm enabled and a match. Without `cnt_tick`, or with the alarm disabled, it does not set.
- R7: Flags hold until cleared by writing 1 to bit 0 (A) or bit 1 (B) of offset 0x20. A new match in the clearing cycle keeps the flag set. Flags also read at offset 0x1C, bit 0 for A and bit 1 for B.
- R8: Reads of unmapped offsets return 0, and writes to them change nothing.
- R9: The backup reset clears values, widths, enables and flags. The system reset clears enables and flags but keeps values and widths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| bkp_rst_n | input | 1 | Synchronous active-low backup reset, clears everything |
| sys_rst_n | input | 1 | Synchronous active-low system reset, clears enables and flags |
| init_mode | input | 1 | Initialization mode, lifts the write protection |
| cnt_tick | input | 1 | Counter updated this cycle |
| cnt | input | CNT_W | Current binary counter value |
| wr_en | input | 1 | Single-cycle write strobe |
| addr | input | ADDR_W | Register offset for write and read |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for `addr`, combinational |
| alarm_flag | output | 2 | Sticky flags, bit 0 alarm A, bit 1 alarm B |

## Verification
The bench builds the block with its default parameters: a 32-bit counter and value, an 8-bit offset space and a 6-bit width field. A 6-bit field can hold values from 33 to 63, so the bench can test widths above the counter size and their clamping to the full 32-bit compare. The same build covers the two other width extremes, 0 (match on every update) and exactly 32. The 15-bit alias split inside a 32-bit value is visible with these defaults, so the bench checks that upper value bits survive alias writes.

// File: rtl/subsec_alarm_pkg.sv
// Shared constants and types for the sub-second alarm matcher.
// Assumes the bus data width equals the counter width.
package subsec_alarm_pkg;
    localparam int N_ALARM      = 2;
    localparam int ALIAS_W      = 15;
    localparam int WIDTH_LSB    = 24;
    localparam int OFF_CTRL     = 'h18;
    localparam int OFF_STATUS   = 'h1C;
    localparam int OFF_CLEAR    = 'h20;
    localparam int OFF_ALIAS0   = 'h44;
    localparam int OFF_VALUE0   = 'h70;
    localparam int OFF_STRIDE   = 4;

    // Per-alarm write strobes produced by the decoder
    typedef struct packed {
        logic val_we;
        logic alias_we;
        logic clr;
    } alarm_wr_t;
endpackage

// File: rtl/subsec_width_mask.sv
// Turns a compare-width code into a bit mask with the low `width` bits set.
// Assumes width codes above CNT_W mean the full width.
module subsec_width_mask #(
    parameter int CNT_W = 32,
    parameter int MFW   = 6
) (
    input  logic [MFW-1:0]   width,
    output logic [CNT_W-1:0] mask
);
    for (genvar i = 0; i < CNT_W; i++) begin : g_bit
        // Bit i takes part in the compare when the width reaches past it
        assign mask[i] = (int'(width) > i);
    end
endmodule

// File: rtl/subsec_alarm_unit.sv
// One alarm: stored value, compare width, enable, masked compare and sticky flag.
// Assumes the strobes come from subsec_alarm_decode, one cycle wide.
module subsec_alarm_unit
    import subsec_alarm_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int MFW   = 6
) (
    input  logic             clk,
    input  logic             bkp_rst_n,
    input  logic             sys_rst_n,
    input  logic             init_mode,
    input  logic             cnt_tick,
    input  logic [CNT_W-1:0] cnt,
    input  alarm_wr_t        wr,
    input  logic             ctrl_we,
    input  logic             ctrl_bit,
    input  logic [CNT_W-1:0] wdata,
    output logic             en_q,
    output logic [CNT_W-1:0] val_q,
    output logic [MFW-1:0]   width_q,
    output logic             flag_q
);
    logic             unlocked;
    logic [CNT_W-1:0] mask;
    logic             hit;

    // Configuration may change only while disabled or in init mode
    assign unlocked = !en_q || init_mode;

    subsec_width_mask #(.CNT_W(CNT_W), .MFW(MFW)) u_mask (
        .width (width_q),
        .mask  (mask)
    );

    // Masked compare qualified by the counter update and the enable
    assign hit = cnt_tick && en_q && (((cnt ^ val_q) & mask) == '0);

    // Alarm value and width storage; system reset leaves them alone
    always_ff @(posedge clk) begin
        if (!bkp_rst_n) begin
            val_q   <= '0;
            width_q <= '0;
        end else if (unlocked) begin
            if (wr.val_we) begin
                val_q <= wdata;
            end else if (wr.alias_we) begin
                val_q[ALIAS_W-1:0] <= wdata[ALIAS_W-1:0];
                width_q            <= wdata[WIDTH_LSB +: MFW];
            end
        end
    end

    // Enable bit, cleared by either reset
    always_ff @(posedge clk) begin
        if (!bkp_rst_n || !sys_rst_n) begin
            en_q <= 1'b0;
        end else if (ctrl_we) begin
            en_q <= ctrl_bit;
        end
    end

    // Sticky flag; a fresh match outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!bkp_rst_n || !sys_rst_n) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (wr.clr) begin
            flag_q <= 1'b0;
        end
    end
endmodule

// File: rtl/subsec_alarm_decode.sv
// Address decode for writes and the combinational read mux.
// Assumes CNT_W is wide enough to hold the width field at WIDTH_LSB.
module subsec_alarm_decode
    import subsec_alarm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 32,
    parameter int MFW    = 6
) (
    input  logic                           wr_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [CNT_W-1:0]               wdata,
    input  logic [N_ALARM-1:0][CNT_W-1:0]  val_q,
    input  logic [N_ALARM-1:0][MFW-1:0]    width_q,
    input  logic [N_ALARM-1:0]             en_q,
    input  logic [N_ALARM-1:0]             flag_q,
    output alarm_wr_t [N_ALARM-1:0]        wr_s,
    output logic                           ctrl_we,
    output logic [CNT_W-1:0]               rdata
);
    // Write strobes for the shared control register and each alarm
    always_comb begin
        ctrl_we = wr_en && (addr == ADDR_W'(OFF_CTRL));
        for (int i = 0; i < N_ALARM; i++) begin
            wr_s[i].val_we   = wr_en && (addr == ADDR_W'(OFF_VALUE0 + OFF_STRIDE * i));
            wr_s[i].alias_we = wr_en && (addr == ADDR_W'(OFF_ALIAS0 + OFF_STRIDE * i));
            wr_s[i].clr      = wr_en && (addr == ADDR_W'(OFF_CLEAR)) && wdata[i];
        end
    end

    // Read mux; anything not listed returns zero
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFF_CTRL)) begin
            rdata[N_ALARM-1:0] = en_q;
        end else if (addr == ADDR_W'(OFF_STATUS)) begin
            rdata[N_ALARM-1:0] = flag_q;
        end
        for (int i = 0; i < N_ALARM; i++) begin
            if (addr == ADDR_W'(OFF_VALUE0 + OFF_STRIDE * i)) begin
                rdata = val_q[i];
            end else if (addr == ADDR_W'(OFF_ALIAS0 + OFF_STRIDE * i)) begin
                rdata                    = '0;
                rdata[ALIAS_W-1:0]       = val_q[i][ALIAS_W-1:0];
                rdata[WIDTH_LSB +: MFW]  = width_q[i];
            end
        end
    end
endmodule

// File: rtl/subsec_alarm_match.sv
// Top of the two-alarm binary sub-second matcher.
// Assumes cnt is already in the clk domain and cnt_tick marks its updates.
module subsec_alarm_match
    import subsec_alarm_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8,
    parameter int MFW    = 6
) (
    input  logic              clk,
    input  logic              bkp_rst_n,
    input  logic              sys_rst_n,
    input  logic              init_mode,
    input  logic              cnt_tick,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic [1:0]        alarm_flag
);
    logic [N_ALARM-1:0][CNT_W-1:0] val_q;
    logic [N_ALARM-1:0][MFW-1:0]   width_q;
    logic [N_ALARM-1:0]            en_q;
    logic [N_ALARM-1:0]            flag_q;
    alarm_wr_t [N_ALARM-1:0]       wr_s;
    logic                          ctrl_we;

    subsec_alarm_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .MFW(MFW)) u_decode (
        .wr_en   (wr_en),
        .addr    (addr),
        .wdata   (wdata),
        .val_q   (val_q),
        .width_q (width_q),
        .en_q    (en_q),
        .flag_q  (flag_q),
        .wr_s    (wr_s),
        .ctrl_we (ctrl_we),
        .rdata   (rdata)
    );

    for (genvar i = 0; i < N_ALARM; i++) begin : g_alarm
        subsec_alarm_unit #(.CNT_W(CNT_W), .MFW(MFW)) u_unit (
            .clk       (clk),
            .bkp_rst_n (bkp_rst_n),
            .sys_rst_n (sys_rst_n),
            .init_mode (init_mode),
            .cnt_tick  (cnt_tick),
            .cnt       (cnt),
            .wr        (wr_s[i]),
            .ctrl_we   (ctrl_we),
            .ctrl_bit  (wdata[i]),
            .wdata     (wdata),
            .en_q      (en_q[i]),
            .val_q     (val_q[i]),
            .width_q   (width_q[i]),
            .flag_q    (flag_q[i])
        );
    end

    assign alarm_flag = flag_q;
endmodule

// File: rtl/subsec_alarm_chk.sv
// Property checker for subsec_alarm_match, bound to every instance.
module subsec_alarm_chk
    import subsec_alarm_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 8
) (
    input logic                          clk,
    input logic                          bkp_rst_n,
    input logic                          sys_rst_n,
    input logic                          init_mode,
    input logic                          cnt_tick,
    input logic                          wr_en,
    input logic [ADDR_W-1:0]             addr,
    input logic [CNT_W-1:0]              wdata,
    input logic [CNT_W-1:0]              rdata,
    input logic [1:0]                    alarm_flag,
    input logic [1:0]                    en_q,
    input logic [1:0][CNT_W-1:0]         val_q
);
    logic mapped;
    assign mapped = (addr == ADDR_W'(OFF_CTRL))   || (addr == ADDR_W'(OFF_STATUS)) ||
                    (addr == ADDR_W'(OFF_ALIAS0)) || (addr == ADDR_W'(OFF_ALIAS0 + OFF_STRIDE)) ||
                    (addr == ADDR_W'(OFF_VALUE0)) || (addr == ADDR_W'(OFF_VALUE0 + OFF_STRIDE));

    // R3
    locked_a_chk: assert property (@(posedge clk) disable iff (!bkp_rst_n || !sys_rst_n)
        (wr_en && en_q[0] && !init_mode) |=> $stable(val_q[0]));

    // R3
    locked_b_chk: assert property (@(posedge clk) disable iff (!bkp_rst_n || !sys_rst_n)
        (wr_en && en_q[1] && !init_mode) |=> $stable(val_q[1]));

    // R6
    flag_cause_a_chk: assert property (@(posedge clk) disable iff (!bkp_rst_n || !sys_rst_n)
        $rose(alarm_flag[0]) |-> $past(cnt_tick && en_q[0]));

    // R6
    flag_cause_b_chk: assert property (@(posedge clk) disable iff (!bkp_rst_n || !sys_rst_n)
        $rose(alarm_flag[1]) |-> $past(cnt_tick && en_q[1]));

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!bkp_rst_n || !sys_rst_n)
        (alarm_flag[0] && !(wr_en && addr == ADDR_W'(OFF_CLEAR) && wdata[0])) |=> alarm_flag[0]);

    // R8
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!bkp_rst_n || !sys_rst_n)
        !mapped |-> (rdata == '0));

    // R9
    sys_reset_keep_chk: assert property (@(posedge clk) disable iff (!bkp_rst_n)
        (!sys_rst_n && !wr_en) |=> $stable(val_q));
endmodule

bind subsec_alarm_match subsec_alarm_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .bkp_rst_n  (bkp_rst_n),
    .sys_rst_n  (sys_rst_n),
    .init_mode  (init_mode),
    .cnt_tick   (cnt_tick),
    .wr_en      (wr_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .alarm_flag (alarm_flag),
    .en_q       (en_q),
    .val_q      (val_q)
);

// File: tb/subsec_alarm_match_test.sv
// Directed bench for subsec_alarm_match: one task per scenario.
module subsec_alarm_match_test;
    localparam int CNT_W  = 32;
    localparam int ADDR_W = 8;

    logic              clk = 1'b0;
    logic              bkp_rst_n = 1'b0;
    logic              sys_rst_n = 1'b0;
    logic              init_mode = 1'b0;
    logic              cnt_tick = 1'b0;
    logic [CNT_W-1:0]  cnt = '0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [CNT_W-1:0]  wdata = '0;
    logic [CNT_W-1:0]  rdata;
    logic [1:0]        alarm_flag;

    int n_chk = 0;
    int n_fail = 0;

    subsec_alarm_match #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .MFW(6)) uut (
        .clk (clk), .bkp_rst_n (bkp_rst_n), .sys_rst_n (sys_rst_n),
        .init_mode (init_mode), .cnt_tick (cnt_tick), .cnt (cnt),
        .wr_en (wr_en), .addr (addr), .wdata (wdata),
        .rdata (rdata), .alarm_flag (alarm_flag)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h00; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b0; addr = a;
        #1 d = rdata;
    endtask

    task automatic tick(input logic [31:0] v);
        @(negedge clk);
        cnt = v; cnt_tick = 1'b1;
        @(negedge clk);
        cnt_tick = 1'b0;
        #1;
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        rd(8'h70, d); check("R9 reset value A", d, 32'h0);
        rd(8'h74, d); check("R9 reset value B", d, 32'h0);
        rd(8'h1C, d); check("R9 reset status", d, 32'h0);
        check("R9 reset flags", {30'd0, alarm_flag}, 32'h0);
    endtask

    task automatic t_value_rw();
        logic [31:0] d;
        wr(8'h70, 32'hDEADBEEF);
        wr(8'h74, 32'h12345678);
        rd(8'h70, d); check("R1 value A readback", d, 32'hDEADBEEF);
        rd(8'h74, d); check("R1 value B readback", d, 32'h12345678);
    endtask

    task automatic t_alias();
        logic [31:0] d;
        wr(8'h44, 32'hCA00_9234);
        rd(8'h70, d); check("R2 alias keeps upper bits", d, 32'hDEAD9234);
        rd(8'h44, d); check("R2 alias readback", d, 32'h0A00_1234);
        wr(8'h74, 32'hFFFF_5555);
        rd(8'h48, d); check("R2 alias B mirrors value", d, 32'h0000_5555);
    endtask

    task automatic t_ctrl_lock();
        logic [31:0] d;
        wr(8'h18, 32'h1);
        rd(8'h18, d); check("R4 control readback", d, 32'h1);
        wr(8'h70, 32'h1111_1111);
        rd(8'h70, d); check("R3 locked value write ignored", d, 32'hDEAD9234);
        wr(8'h44, 32'h0100_0000);
        rd(8'h44, d); check("R3 locked alias write ignored", d, 32'h0A00_1234);
        wr(8'h74, 32'h0000_00A5);
        rd(8'h74, d); check("R3 disabled alarm writable", d, 32'h0000_00A5);
        init_mode = 1'b1;
        wr(8'h70, 32'h0000_00A5);
        rd(8'h70, d); check("R3 init mode unlocks", d, 32'h0000_00A5);
        wr(8'h44, 32'h0800_00A5);
        init_mode = 1'b0;
        wr(8'h18, 32'h0);
        rd(8'h18, d); check("R4 control cleared", d, 32'h0);
    endtask

    task automatic t_match();
        logic [31:0] d;
        wr(8'h18, 32'h1);
        tick(32'hFFFF_FFA5);
        check("R5 R6 masked match sets A", {30'd0, alarm_flag}, 32'h1);
        rd(8'h1C, d); check("R7 status shows A", d, 32'h1);
        tick(32'h0000_0000);
        tick(32'h0000_1234);
        check("R7 flag sticky", {30'd0, alarm_flag}, 32'h1);
        wr(8'h20, 32'h1);
        check("R7 clear drops flag", {30'd0, alarm_flag}, 32'h0);
        tick(32'h0000_00A4);
        check("R5 low-bit mismatch no flag", {30'd0, alarm_flag}, 32'h0);
        @(negedge clk);
        cnt = 32'h0000_00A5; cnt_tick = 1'b0;
        @(negedge clk);
        #1 check("R6 no tick no flag", {30'd0, alarm_flag}, 32'h0);
    endtask

    task automatic t_set_wins();
        tick(32'h0000_00A5);
        @(negedge clk);
        cnt = 32'h0000_00A5; cnt_tick = 1'b1;
        wr_en = 1'b1; addr = 8'h20; wdata = 32'h1;
        @(negedge clk);
        cnt_tick = 1'b0; wr_en = 1'b0; addr = 8'h00; wdata = '0;
        #1 check("R7 match outranks clear", {30'd0, alarm_flag}, 32'h1);
        wr(8'h20, 32'h1);
    endtask

    task automatic t_width_edges();
        init_mode = 1'b1;
        wr(8'h44, 32'h0000_0000);
        tick(32'h1357_9BDF);
        check("R5 width 0 matches any", {30'd0, alarm_flag}, 32'h1);
        wr(8'h20, 32'h1);
        wr(8'h70, 32'h8000_0001);
        wr(8'h44, 32'h2800_0001);
        tick(32'h0000_0001);
        check("R5 width 40 top bit compared", {30'd0, alarm_flag}, 32'h0);
        tick(32'h8000_0001);
        check("R5 width 40 full match", {30'd0, alarm_flag}, 32'h1);
        wr(8'h20, 32'h1);
        wr(8'h44, 32'h2000_0001);
        tick(32'h0000_0001);
        check("R5 width 32 top bit compared", {30'd0, alarm_flag}, 32'h0);
        init_mode = 1'b0;
        wr(8'h18, 32'h0);
        tick(32'h8000_0001);
        check("R6 disabled no flag", {30'd0, alarm_flag}, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        rd(8'h00, d); check("R8 unmapped read 0x00", d, 32'h0);
        rd(8'h7C, d); check("R8 unmapped read 0x7C", d, 32'h0);
        wr(8'h7C, 32'hFFFF_FFFF);
        wr(8'h71, 32'hFFFF_FFFF);
        rd(8'h70, d); check("R8 unmapped write no effect", d, 32'h8000_0001);
    endtask

    task automatic t_resets();
        logic [31:0] d;
        wr(8'h18, 32'h3);
        tick(32'h8000_0001);
        @(negedge clk); sys_rst_n = 1'b0;
        @(negedge clk); sys_rst_n = 1'b1;
        rd(8'h70, d); check("R9 system reset keeps value", d, 32'h8000_0001);
        rd(8'h44, d); check("R9 system reset keeps width", d, 32'h2000_0001);
        rd(8'h18, d); check("R9 system reset clears enables", d, 32'h0);
        check("R9 system reset clears flags", {30'd0, alarm_flag}, 32'h0);
        @(negedge clk); bkp_rst_n = 1'b0;
        @(negedge clk); bkp_rst_n = 1'b1;
        rd(8'h70, d); check("R9 backup reset clears value", d, 32'h0);
        rd(8'h48, d); check("R9 backup reset clears alias", d, 32'h0);
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        bkp_rst_n = 1'b1; sys_rst_n = 1'b1;
        t_reset_state();
        t_value_rw();
        t_alias();
        t_ctrl_lock();
        t_match();
        t_set_wins();
        t_width_edges();
        t_unmapped();
        t_resets();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule